// File: doc/BRIEF.md
# Polled Single-Byte Serial Port

A serial port for a 32-bit register bus with one byte of storage in each direction. Software finds out what to do by polling a status word with two flags. One flag says a received byte is waiting. The other says the transmitter can take a new byte. A byte written to the transmit register goes out through a shift register as an 8N1 frame. A byte that arrives on the line is kept until software reads it. While that byte is still waiting, the receiver takes no new byte.

The bit time is set by a divider on an input port, counted in clock cycles per bit. Each frame captures the divider when it starts, so the caller should hold it at 4 or more.

An access that hits none of the defined offsets raises an "unimplemented" strobe during that access. A line overrun raises a sticky flag that stays set until reset.

Top module: `poll_uart`

## Requirements
- R1: After reset the status word reads 0x00000002, the receive register reads 0, `tx_o` is high and `overrun_o` is low.
- R2: The register map uses byte offsets. Transmit data is at 0x00, receive data at 0x04 and status at 0x14. In the status word, bit 0 means a received byte is waiting, bit 1 means the transmitter is ready, and bits 31:2 read 0. A read of the transmit offset returns 0.
- R3: A write to the transmit offset while the transmitter is ready sends `wdata_i[7:0]` as one frame: a low start bit, the 8 data bits LSB first, then a high stop bit. Each bit lasts `baud_div_i` cycles, and the start bit drives `tx_o` from the clock edge of the write onward.
- R4: An accepted transmit write clears the transmitter-ready bit. The bit reads 1 again exactly 10×`baud_div_i` cycles after the write edge. A transmit write made while the bit is 0 is discarded and leaves the frame in flight unchanged.
- R5: The receiver passes `rx_i` through two flops before use. It detects a start bit, checks it again at mid-bit, and samples each data bit and the stop bit at mid-bit. A frame whose stop bit is low is rejected: the received-byte bit is not set and the overrun flag is not raised.
- R6: A valid frame that completes while status bit 0 is clear is stored and sets bit 0. A read of offset 0x04 returns the stored byte in bits 7:0, with zeros above, and clears bit 0 in that same access.
- R7: A valid frame that completes while status bit 0 is set is dropped. The stored byte is kept, and `overrun_o` goes high and stays high until reset.
- R8: Writes to the status offset change no state, whatever the data.
- R9: An access to any byte address other than 0x00, 0x04 and 0x14 drives `unimpl_o` high during that access. A read there returns 0, and a write there changes no state and sends nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| baud_div_i | input | 16 | Clock cycles per serial bit, captured at frame start |
| req_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 5 | Byte address in the register window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the access cycle |
| unimpl_o | output | 1 | Access hits an undefined offset |
| rx_i | input | 1 | Serial input line |
| tx_o | output | 1 | Serial output line, idle high |
| overrun_o | output | 1 | Sticky flag for a frame dropped on overrun |

## Verification
Some rules are checked by assertions on every cycle:
- an RX read with a byte waiting clears the received-byte bit;
- the stored byte holds still while that bit stays set;
- the overrun flag never falls;
- the line is high whenever the transmitter is ready;
- an accepted transmit write drops the ready bit;
- reads of undefined offsets and the upper status bits return zero.

Other behaviour only the bench scenarios show:
- the bit order and bit timing of frames;
- the exact cycle in which ready comes back;
- that a write made while busy is discarded;
- that frames with a low stop bit are rejected;
- that status writes and undefined writes leave no trace.

// File: rtl/poll_uart_pkg.sv
package poll_uart_pkg;
  // byte offsets of the defined registers
  localparam int unsigned OFF_TX = 32'h00;
  localparam int unsigned OFF_RX = 32'h04;
  localparam int unsigned OFF_ST = 32'h14;
  // status bit positions
  localparam int unsigned ST_RXV = 0;
  localparam int unsigned ST_TXR = 1;
  localparam int unsigned FRAME_BITS = 10;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/poll_uart_tx.sv
module poll_uart_tx #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ready_o,
  output logic              tx_o
);
  import poll_uart_pkg::*;
  localparam int unsigned SH_W = DATA_W + 2;
  localparam int unsigned BC_W = $clog2(SH_W + 1);

  logic [SH_W-1:0]  shreg_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [BC_W-1:0]  left_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '1;
      div_q   <= '0;
      cnt_q   <= '0;
      left_q  <= '0;
      busy_q  <= 1'b0;
    end else if (!busy_q) begin
      if (start_i) begin
        shreg_q <= {1'b1, data_i, 1'b0};
        div_q   <= div_i;
        cnt_q   <= '0;
        left_q  <= BC_W'(SH_W);
        busy_q  <= 1'b1;
      end
    end else if (cnt_q == div_q - 1'b1) begin
      cnt_q   <= '0;
      shreg_q <= {1'b1, shreg_q[SH_W-1:1]};
      left_q  <= left_q - 1'b1;
      if (left_q == BC_W'(1)) busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign ready_o = !busy_q;
  assign tx_o    = busy_q ? shreg_q[0] : 1'b1;
endmodule

// File: rtl/poll_uart_rx.sv
module poll_uart_rx #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  div_i,
  input  logic              rx_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  import poll_uart_pkg::*;
  localparam int unsigned IDX_W = $clog2(DATA_W);

  logic             sync0_q, sync1_q;
  rx_state_e        state_q;
  logic [DIV_W-1:0] div_q, cnt_q;
  logic [IDX_W-1:0] idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic             bit_end, half_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync0_q <= 1'b1;
      sync1_q <= 1'b1;
    end else begin
      sync0_q <= rx_i;
      sync1_q <= sync0_q;
    end
  end

  assign bit_end  = (cnt_q == div_q - 1'b1);
  assign half_end = (cnt_q == (div_q >> 1) - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      div_q   <= '0;
      cnt_q   <= '0;
      idx_q   <= '0;
      shreg_q <= '0;
      valid_o <= 1'b0;
      data_o  <= '0;
    end else begin
      valid_o <= 1'b0;
      case (state_q)
        RX_IDLE: if (!sync1_q) begin
          state_q <= RX_START;
          div_q   <= div_i;
          cnt_q   <= '0;
        end
        RX_START: begin
          if (half_end) begin
            cnt_q   <= '0;
            idx_q   <= '0;
            state_q <= sync1_q ? RX_IDLE : RX_DATA;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_DATA: begin
          if (bit_end) begin
            cnt_q   <= '0;
            shreg_q <= {sync1_q, shreg_q[DATA_W-1:1]};
            if (idx_q == IDX_W'(DATA_W - 1)) state_q <= RX_STOP;
            else idx_q <= idx_q + 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_STOP: begin
          if (bit_end) begin
            cnt_q <= '0;
            if (sync1_q) begin
              valid_o <= 1'b1;
              data_o  <= shreg_q;
              state_q <= RX_IDLE;
            end else begin
              state_q <= RX_WAIT_HI;   // bad stop: wait for a quiet line
            end
          end else cnt_q <= cnt_q + 1'b1;
        end
        RX_WAIT_HI: if (sync1_q) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/poll_uart.sv
module poll_uart #(
  parameter int unsigned DIV_W  = 16,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DIV_W-1:0]  baud_div_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  wdata_i,
  output logic [BUS_W-1:0]  rdata_o,
  output logic              unimpl_o,
  input  logic              rx_i,
  output logic              tx_o,
  output logic              overrun_o
);
  import poll_uart_pkg::*;

  logic hit_tx, hit_rx, hit_st;
  logic tx_rdy, tx_start;
  logic rx_valid;
  logic [DATA_W-1:0] rx_byte;
  logic rx_rdy_q, ovr_q;
  logic [DATA_W-1:0] rx_data_q;
  logic rd_rx;

  assign hit_tx = req_i && (addr_i == ADDR_W'(OFF_TX));
  assign hit_rx = req_i && (addr_i == ADDR_W'(OFF_RX));
  assign hit_st = req_i && (addr_i == ADDR_W'(OFF_ST));
  assign unimpl_o = req_i && !(hit_tx || hit_rx || hit_st);

  assign tx_start = hit_tx && we_i && tx_rdy;
  assign rd_rx    = hit_rx && !we_i;

  poll_uart_tx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) i_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (baud_div_i),
    .start_i (tx_start),
    .data_i  (wdata_i[DATA_W-1:0]),
    .ready_o (tx_rdy),
    .tx_o    (tx_o)
  );

  poll_uart_rx #(.DIV_W(DIV_W), .DATA_W(DATA_W)) i_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .div_i   (baud_div_i),
    .rx_i    (rx_i),
    .valid_o (rx_valid),
    .data_o  (rx_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_rdy_q  <= 1'b0;
      rx_data_q <= '0;
      ovr_q     <= 1'b0;
    end else begin
      if (rx_valid && !rx_rdy_q) begin
        rx_data_q <= rx_byte;
        rx_rdy_q  <= 1'b1;
      end else if (rd_rx) begin
        rx_rdy_q  <= 1'b0;
      end
      if (rx_valid && rx_rdy_q) ovr_q <= 1'b1;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (hit_rx) rdata_o[DATA_W-1:0] = rx_data_q;
      if (hit_st) begin
        rdata_o[ST_RXV] = rx_rdy_q;
        rdata_o[ST_TXR] = tx_rdy;
      end
    end
  end

  assign overrun_o = ovr_q;
endmodule

// File: rtl/poll_uart_chk.sv
module poll_uart_chk #(
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BUS_W  = 32,
  parameter int unsigned DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [BUS_W-1:0]  rdata_o,
  input logic              unimpl_o,
  input logic              tx_o,
  input logic              overrun_o,
  input logic              rx_rdy,
  input logic              tx_rdy,
  input logic [DATA_W-1:0] rx_data
);
  import poll_uart_pkg::*;

  a_r6_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_RX) && rx_rdy) |=> !rx_rdy);

  a_r7_held_byte_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_rdy && $past(rx_rdy)) |-> $stable(rx_data));

  a_r7_overrun_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);

  a_r3_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_rdy |-> tx_o);

  a_r4_write_takes_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i == ADDR_W'(OFF_TX) && tx_rdy) |=> !tx_rdy);

  a_r9_unimpl_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unimpl_o && !we_i) |-> (rdata_o == '0));

  a_r2_status_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i == ADDR_W'(OFF_ST)) |-> (rdata_o[BUS_W-1:2] == '0));
endmodule

bind poll_uart poll_uart_chk #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .addr_i    (addr_i),
  .rdata_o   (rdata_o),
  .unimpl_o  (unimpl_o),
  .tx_o      (tx_o),
  .overrun_o (overrun_o),
  .rx_rdy    (rx_rdy_q),
  .tx_rdy    (tx_rdy),
  .rx_data   (rx_data_q)
);

// File: tb/test_poll_uart.sv
module test_poll_uart;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] baud = 16'd8;
  logic        req = 1'b0, we = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        unimpl, rx = 1'b1, tx, ovr;
  int          checks = 0, errors = 0;
  logic        tx_s [0:511];
  logic        rd_s [0:511];

  always #4 clk = ~clk;

  poll_uart i_poll_uart (
    .clk_i(clk), .rst_ni(rst_n), .baud_div_i(baud), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .unimpl_o(unimpl),
    .rx_i(rx), .tx_o(tx), .overrun_o(ovr)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_rd(input logic [4:0] a, output logic [31:0] d, output logic u);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata; u = unimpl;
    @(posedge clk); #1 req = 1'b0;
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, output logic u);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    #1 u = unimpl;
    @(posedge clk); #1 req = 1'b0; we = 1'b0;
  endtask

  function automatic logic [31:0] status_exp(input bit rxv, input bit txr);
    return {30'd0, txr, rxv};
  endfunction

  // transmit one byte while polling status every cycle
  task automatic tx_frame(input logic [7:0] d, input int div, input bit inject);
    logic [7:0] got;
    @(negedge clk);
    baud = 16'(div);
    req = 1'b1; we = 1'b1; addr = 5'h00; wdata = {$urandom % 256, 8'h00, 8'h00, d};
    @(posedge clk);
    for (int j = 1; j <= 10 * div + 2; j++) begin
      @(negedge clk);
      if (inject && j == 5) begin
        we = 1'b1; addr = 5'h00; wdata = {24'h0, ~d};
      end else begin
        we = 1'b0; addr = 5'h14;
      end
      #1 tx_s[j] = tx; rd_s[j] = rdata[1];
    end
    @(negedge clk); req = 1'b0; we = 1'b0;
    for (int b = 0; b < 8; b++) got[b] = tx_s[(b + 1) * div + div / 2 + 1];
    chk(tx_s[div / 2 + 1] == 1'b0, "R3 start bit", 32'(tx_s[div / 2 + 1]), 32'd0);
    chk(got == d, "R3 data bits", 32'(got), 32'(d));
    chk(tx_s[9 * div + div / 2 + 1] == 1'b1, "R3 stop bit", 32'(tx_s[9 * div + div / 2 + 1]), 32'd1);
    chk(rd_s[1] == 1'b0 && rd_s[10 * div] == 1'b0, "R4 ready low during frame",
        32'({rd_s[1], rd_s[10 * div]}), 32'd0);
    chk(rd_s[10 * div + 1] == 1'b1, "R4 ready back after stop", 32'(rd_s[10 * div + 1]), 32'd1);
    if (inject)
      chk(tx_s[10 * div + 2] == 1'b1, "R4 busy write discarded", 32'(tx_s[10 * div + 2]), 32'd1);
  endtask

  task automatic rx_frame(input logic [7:0] d, input bit stop_ok, input int div);
    @(negedge clk);
    baud = 16'(div);
    for (int b = 0; b < 10; b++) begin
      rx = (b == 0) ? 1'b0 : (b == 9) ? stop_ok : d[b - 1];
      repeat (div) @(negedge clk);
    end
    rx = 1'b1;
    repeat (div + 6) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic u;
    logic [7:0] b0, b1;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(5'h14, d, u);
    chk(d == status_exp(0, 1), "R1 status after reset", d, 32'h2);
    bus_rd(5'h04, d, u);
    chk(d == 32'h0, "R1 rx after reset", d, 32'h0);
    chk(tx == 1'b1 && ovr == 1'b0, "R1 line and overrun", {30'd0, tx, ovr}, 32'h2);
    // R2 map: tx offset reads zero, not unimplemented
    bus_rd(5'h00, d, u);
    chk(d == 32'h0 && !u, "R2 tx offset read", d, 32'h0);

    // R9 undefined offsets
    foreach (b0[i]) begin end
    for (int k = 0; k < 6; k++) begin
      logic [4:0] a;
      case (k)
        0: a = 5'h08; 1: a = 5'h0C; 2: a = 5'h10;
        3: a = 5'h18; 4: a = 5'h1C; default: a = 5'h02;
      endcase
      bus_rd(a, d, u);
      chk(d == 32'h0 && u, "R9 undefined read", {d[30:0], u}, 32'h1);
    end
    bus_wr(5'h08, 32'h0000_00A5, u);
    chk(u == 1'b1, "R9 undefined write flagged", 32'(u), 32'd1);
    repeat (3) @(negedge clk);
    chk(tx == 1'b1, "R9 undefined write sends nothing", 32'(tx), 32'd1);
    bus_rd(5'h14, d, u);
    chk(d == status_exp(0, 1), "R9 status untouched", d, 32'h2);

    // R8 status write on empty port
    bus_wr(5'h14, 32'hFFFF_FFFF, u);
    bus_rd(5'h14, d, u);
    chk(d == status_exp(0, 1) && !u, "R8 status write ignored", d, 32'h2);

    // R3/R4 directed corner bytes and busy-write discard
    tx_frame(8'h00, 4, 1'b0);
    tx_frame(8'hFF, 5, 1'b1);
    tx_frame(8'h81, 8, 1'b1);
    for (int i = 0; i < 8; i++)
      tx_frame(8'($urandom), int'($urandom_range(4, 12)), i[0]);

    // R5/R6 receive path, random patterns
    for (int i = 0; i < 10; i++) begin
      b0 = 8'($urandom);
      rx_frame(b0, 1'b1, int'($urandom_range(4, 16)));
      bus_rd(5'h14, d, u);
      chk(d == status_exp(1, 1), "R6 byte waiting", d, 32'h3);
      bus_rd(5'h04, d, u);
      chk(d == {24'd0, b0}, "R5 received byte", d, {24'd0, b0});
      bus_rd(5'h14, d, u);
      chk(d == status_exp(0, 1), "R6 read clears flag", d, 32'h2);
    end

    // R5 frame with low stop bit rejected
    rx_frame(8'h5A, 1'b0, 8);
    bus_rd(5'h14, d, u);
    chk(d == status_exp(0, 1), "R5 bad stop rejected", d, 32'h2);
    chk(ovr == 1'b0, "R5 no overrun on bad stop", 32'(ovr), 32'd0);
    rx_frame(8'h3C, 1'b1, 8);
    bus_rd(5'h04, d, u);
    chk(d == 32'h3C, "R5 recovers after bad stop", d, 32'h3C);

    // R8 status write while a byte waits
    b0 = 8'hC3;
    rx_frame(b0, 1'b1, 6);
    bus_wr(5'h14, 32'h0000_0000, u);
    bus_wr(5'h14, 32'hFFFF_FFFF, u);
    bus_rd(5'h14, d, u);
    chk(d == status_exp(1, 1), "R8 status keeps flags", d, 32'h3);

    // R7 overrun: second byte while first waits
    b1 = 8'h69;
    rx_frame(b1, 1'b1, 6);
    chk(ovr == 1'b1, "R7 overrun raised", 32'(ovr), 32'd1);
    bus_rd(5'h04, d, u);
    chk(d == {24'd0, b0}, "R7 held byte kept", d, {24'd0, b0});
    bus_rd(5'h14, d, u);
    chk(d == status_exp(0, 1), "R7 flag cleared by read", d, 32'h2);
    rx_frame(8'h11, 1'b1, 6);
    chk(ovr == 1'b1, "R7 overrun sticky", 32'(ovr), 32'd1);
    bus_rd(5'h04, d, u);
    chk(d == 32'h11, "R6 reception after overrun", d, 32'h11);

    finish_run();
  end
endmodule